// File: doc/BRIEF.md
# Barrel Shifter with Condition Flags

This block shifts a 32-bit operand left logically, right logically or right arithmetically by a count taken from a count input, and produces the shifted word together with a full set of condition flags (negative, zero, overflow, carry and extend). It is meant to sit in an execution stage of an integer datapath, where the shift result and flags feed the register file and the condition-code register.

Only the low six bits of the count are used, so every count from 0 to 63 is legal. Counts of 32 and above have defined results and carries. A count of zero leaves the operand untouched and carries the previous carry flag through instead of clearing it. The datapath is combinational. An optional output register, on by default, adds one cycle of latency.

Top module: `shiftcc_unit`

## Requirements
- R1: Only the low six bits of `cnt_i` are used (count modulo 64); for example a count of 68 acts as 4 and a count of 64 acts as 0.
- R2: With an effective count of 0 and any shift kind, the result equals `val_i`, and both C and X equal `prev_c_i`.
- R3: Kind 2'b00 (logical left), count n from 1 to 31: the result is `val_i << n` and C is input bit 32−n. At n = 32 the result is 0 and C is input bit 0. Above 32 the result is 0 and C is 0.
- R4: Kind 2'b01 (logical right), count n from 1 to 31: the result is `val_i >> n` with zero fill and C is input bit n−1. At n = 32 the result is 0 and C is input bit 31. Above 32 the result is 0 and C is 0.
- R5: Kind 2'b10 (arithmetic right), count n from 1 to 31: the result is `val_i` shifted right with sign fill and C is input bit n−1. At n of 32 or more every result bit equals input bit 31, and so does C.
- R6: For a nonzero effective count with kinds 2'b00 to 2'b10, X equals the new C.
- R7: N equals result bit 31, and Z is 1 exactly when the result is zero.
- R8: V is always 0.
- R9: Kind 2'b11 is a hold code: for any count, the result equals `val_i` and C and X equal `prev_c_i`.
- R10: With `REG_OUT`=1, the outputs show the result for the inputs present at the previous rising clock edge. A synchronous active-high `rst` clears the result and all flags to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| val_i | input | 32 | Operand to shift |
| cnt_i | input | 8 | Shift count; only the low six bits are used |
| kind_i | input | 2 | Shift kind: 00 left, 01 logical right, 10 arithmetic right, 11 hold |
| prev_c_i | input | 1 | Carry flag before this operation |
| res_o | output | 32 | Shifted result |
| n_o | output | 1 | Negative flag |
| z_o | output | 1 | Zero flag |
| v_o | output | 1 | Overflow flag (always 0) |
| c_o | output | 1 | Carry flag |
| x_o | output | 1 | Extend flag |

## Verification
The checker keeps its own copy of the inputs, delayed to match the output register. It assumes that the inputs are stable when they are sampled at the rising edge and that they carry no X or Z values once reset has been released. The properties are armed only from the first edge after reset, so they never compare against inputs captured while reset was active. The bench drives every input on the falling edge, holds it for a full cycle, uses only the four defined kind codes with fully known values, and takes counts above 63 only to probe the modulo rule.

// File: rtl/shiftcc_pkg.sv
package shiftcc_pkg;

    typedef enum logic [1:0] {
        SK_LSL  = 2'b00,
        SK_LSR  = 2'b01,
        SK_ASR  = 2'b10,
        SK_HOLD = 2'b11
    } shift_kind_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
        logic x;
    } ccr_t;

    // Count bits needed so that counts up to twice the word width are distinct.
    function automatic int count_bits(input int word_w);
        return $clog2(word_w) + 1;
    endfunction

    // True when the operation keeps the operand and the incoming carry.
    function automatic logic is_passthru(input shift_kind_e k, input logic cnt_zero);
        return cnt_zero || (k == SK_HOLD);
    endfunction

endpackage

// File: rtl/shiftcc_barrel.sv
module shiftcc_barrel #(
    parameter int DW   = 33,
    parameter int SW   = 6,
    parameter bit LEFT = 1'b1
) (
    input  logic [DW-1:0] din,
    input  logic [SW-1:0] amt,
    input  logic          fill,
    output logic [DW-1:0] dout
);
    logic [DW-1:0] stg [SW+1];

    assign stg[0] = din;

    for (genvar i = 0; i < SW; i++) begin : g_stage
        localparam int SH = 1 << i;
        if (SH >= DW) begin : g_all
            assign stg[i+1] = amt[i] ? {DW{fill}} : stg[i];
        end else if (LEFT) begin : g_left
            assign stg[i+1] = amt[i] ? {stg[i][DW-SH-1:0], {SH{fill}}} : stg[i];
        end else begin : g_right
            assign stg[i+1] = amt[i] ? {{SH{fill}}, stg[i][DW-1:SH]} : stg[i];
        end
    end

    assign dout = stg[SW];
endmodule

// File: rtl/shiftcc_core.sv
module shiftcc_core
    import shiftcc_pkg::*;
#(
    parameter int W  = 32,
    parameter int CW = 6
) (
    input  logic [W-1:0]  val,
    input  logic [CW-1:0] cnt,
    input  shift_kind_e   kind,
    input  logic          prev_c,
    output logic [W-1:0]  res,
    output logic          carry
);
    localparam int DW = W + 1;

    logic [DW-1:0] lout;
    logic [DW-1:0] rout;
    logic          rfill;

    // Left: one guard bit above the word catches the last bit out.
    shiftcc_barrel #(.DW(DW), .SW(CW), .LEFT(1'b1)) u_left (
        .din  ({1'b0, val}),
        .amt  (cnt),
        .fill (1'b0),
        .dout (lout)
    );

    // Right: one guard bit below the word catches the last bit out.
    assign rfill = (kind == SK_ASR) && val[W-1];

    shiftcc_barrel #(.DW(DW), .SW(CW), .LEFT(1'b0)) u_right (
        .din  ({val, 1'b0}),
        .amt  (cnt),
        .fill (rfill),
        .dout (rout)
    );

    always_comb begin
        if (is_passthru(kind, cnt == '0)) begin
            res   = val;
            carry = prev_c;
        end else if (kind == SK_LSL) begin
            res   = lout[W-1:0];
            carry = lout[W];
        end else begin
            res   = rout[W:1];
            carry = rout[0];
        end
    end
endmodule

// File: rtl/shiftcc_flags.sv
module shiftcc_flags
    import shiftcc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] res,
    input  logic         carry,
    output ccr_t         ccr
);
    always_comb begin
        ccr.n = res[W-1];
        ccr.z = (res == '0);
        ccr.v = 1'b0;
        ccr.c = carry;
        ccr.x = carry;
    end
endmodule

// File: rtl/shiftcc_unit.sv
module shiftcc_unit
    import shiftcc_pkg::*;
#(
    parameter int W        = 32,
    parameter int CNT_IN_W = 8,
    parameter bit REG_OUT  = 1'b1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [W-1:0]        val_i,
    input  logic [CNT_IN_W-1:0] cnt_i,
    input  logic [1:0]          kind_i,
    input  logic                prev_c_i,
    output logic [W-1:0]        res_o,
    output logic                n_o,
    output logic                z_o,
    output logic                v_o,
    output logic                c_o,
    output logic                x_o
);
    localparam int CW = count_bits(W);

    logic [CW-1:0] cnt_eff;
    logic [W-1:0]  res_c;
    logic          carry_c;
    ccr_t          ccr_c;
    logic [W-1:0]  res_q;
    ccr_t          ccr_q;

    assign cnt_eff = cnt_i[CW-1:0];

    if (CNT_IN_W > CW) begin : g_cnt_hi
        logic unused_cnt_hi;
        assign unused_cnt_hi = ^cnt_i[CNT_IN_W-1:CW];
    end

    shiftcc_core #(.W(W), .CW(CW)) u_core (
        .val    (val_i),
        .cnt    (cnt_eff),
        .kind   (shift_kind_e'(kind_i)),
        .prev_c (prev_c_i),
        .res    (res_c),
        .carry  (carry_c)
    );

    shiftcc_flags #(.W(W)) u_flags (
        .res   (res_c),
        .carry (carry_c),
        .ccr   (ccr_c)
    );

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                res_q <= '0;
                ccr_q <= '0;
            end else begin
                res_q <= res_c;
                ccr_q <= ccr_c;
            end
        end
    end else begin : g_comb
        logic unused_clk_rst;
        assign unused_clk_rst = clk ^ rst;
        assign res_q = res_c;
        assign ccr_q = ccr_c;
    end

    assign res_o = res_q;
    assign n_o   = ccr_q.n;
    assign z_o   = ccr_q.z;
    assign v_o   = ccr_q.v;
    assign c_o   = ccr_q.c;
    assign x_o   = ccr_q.x;
endmodule

// File: rtl/shiftcc_unit_chk.sv
module shiftcc_unit_chk
    import shiftcc_pkg::*;
#(
    parameter int W        = 32,
    parameter int CNT_IN_W = 8,
    parameter bit REG_OUT  = 1'b1
) (
    input logic                clk,
    input logic                rst,
    input logic [W-1:0]        val_i,
    input logic [CNT_IN_W-1:0] cnt_i,
    input logic [1:0]          kind_i,
    input logic                prev_c_i,
    input logic [W-1:0]        res_o,
    input logic                n_o,
    input logic                z_o,
    input logic                v_o,
    input logic                c_o,
    input logic                x_o
);
    localparam int CW = count_bits(W);

    logic          armed;
    logic [W-1:0]  d_val;
    logic [CW-1:0] d_cnt;
    logic [1:0]    d_kind;
    logic          d_pc;

    if (CNT_IN_W > CW) begin : g_cnt_hi
        logic unused_chk_cnt_hi;
        assign unused_chk_cnt_hi = ^cnt_i[CNT_IN_W-1:CW];
    end

    if (REG_OUT) begin : g_dly
        always_ff @(posedge clk) begin
            if (rst) begin
                armed  <= 1'b0;
                d_val  <= '0;
                d_cnt  <= '0;
                d_kind <= '0;
                d_pc   <= 1'b0;
            end else begin
                armed  <= 1'b1;
                d_val  <= val_i;
                d_cnt  <= cnt_i[CW-1:0];
                d_kind <= kind_i;
                d_pc   <= prev_c_i;
            end
        end
    end else begin : g_nodly
        assign armed  = 1'b1;
        assign d_val  = val_i;
        assign d_cnt  = cnt_i[CW-1:0];
        assign d_kind = kind_i;
        assign d_pc   = prev_c_i;
    end

    // R2: zero count keeps operand and carries the old carry into C and X
    a_r2_zero_keeps: assert property (@(posedge clk) disable iff (rst)
        armed && d_cnt == '0 |-> res_o == d_val && c_o == d_pc && x_o == d_pc);

    // R3: left shifts of the full width or more
    a_r3_left_wide: assert property (@(posedge clk) disable iff (rst)
        armed && d_kind == 2'b00 && d_cnt >= CW'(W) |->
            res_o == '0 && c_o == ((d_cnt == CW'(W)) ? d_val[0] : 1'b0));

    // R4: logical right shifts of the full width or more
    a_r4_right_wide: assert property (@(posedge clk) disable iff (rst)
        armed && d_kind == 2'b01 && d_cnt >= CW'(W) |->
            res_o == '0 && c_o == ((d_cnt == CW'(W)) ? d_val[W-1] : 1'b0));

    // R5: arithmetic right shifts of the full width or more fill with the sign
    a_r5_sign_fill: assert property (@(posedge clk) disable iff (rst)
        armed && d_kind == 2'b10 && d_cnt >= CW'(W) |->
            res_o == {W{d_val[W-1]}} && c_o == d_val[W-1] && n_o == d_val[W-1]);

    // R9: hold code passes the operand and the old carry
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        armed && d_kind == 2'b11 |-> res_o == d_val && c_o == d_pc);

    // R7, R8: a set zero flag implies a zero word, and overflow stays clear
    a_r7_zero_word: assert property (@(posedge clk) disable iff (rst)
        armed && z_o |-> res_o == '0 && !v_o);

endmodule

bind shiftcc_unit shiftcc_unit_chk #(
    .W(W), .CNT_IN_W(CNT_IN_W), .REG_OUT(REG_OUT)
) u_chk (.*);

// File: tb/shiftcc_unit_test.sv
module shiftcc_unit_test;

    typedef struct packed {
        logic [7:0]  req;
        logic [1:0]  kind;
        logic [7:0]  cnt;
        logic        pc;
        logic [31:0] val;
        logic [31:0] res;
        logic        c;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{8'd3, 2'b00, 8'd4,  1'b0, 32'h8765_4321, 32'h7654_3210, 1'b0}, // R3
        '{8'd3, 2'b00, 8'd1,  1'b0, 32'h8000_0001, 32'h0000_0002, 1'b1}, // R3
        '{8'd3, 2'b00, 8'd32, 1'b0, 32'h0000_0001, 32'h0000_0000, 1'b1}, // R3
        '{8'd3, 2'b00, 8'd33, 1'b1, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0}, // R3
        '{8'd2, 2'b00, 8'd0,  1'b1, 32'h1234_5678, 32'h1234_5678, 1'b1}, // R2
        '{8'd4, 2'b01, 8'd8,  1'b0, 32'h0000_0180, 32'h0000_0001, 1'b1}, // R4
        '{8'd4, 2'b01, 8'd32, 1'b0, 32'h8000_0000, 32'h0000_0000, 1'b1}, // R4
        '{8'd4, 2'b01, 8'd63, 1'b1, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0}, // R4
        '{8'd5, 2'b10, 8'd4,  1'b1, 32'h8000_0010, 32'hF800_0001, 1'b0}, // R5
        '{8'd5, 2'b10, 8'd40, 1'b0, 32'h8000_0000, 32'hFFFF_FFFF, 1'b1}, // R5
        '{8'd5, 2'b10, 8'd32, 1'b1, 32'h7FFF_FFFF, 32'h0000_0000, 1'b0}, // R5
        '{8'd1, 2'b00, 8'd68, 1'b1, 32'h0000_000F, 32'h0000_00F0, 1'b0}, // R1
        '{8'd1, 2'b01, 8'd64, 1'b1, 32'hABCD_0000, 32'hABCD_0000, 1'b1}, // R1
        '{8'd9, 2'b11, 8'd5,  1'b1, 32'h5555_0000, 32'h5555_0000, 1'b1}, // R9
        '{8'd9, 2'b11, 8'd0,  1'b0, 32'h0000_0000, 32'h0000_0000, 1'b0}, // R9
        '{8'd5, 2'b10, 8'd31, 1'b0, 32'h4000_0000, 32'h0000_0000, 1'b1}  // R5
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] val_i = '0;
    logic [7:0]  cnt_i = '0;
    logic [1:0]  kind_i = '0;
    logic        prev_c_i = 1'b0;
    logic [31:0] res_o;
    logic        n_o, z_o, v_o, c_o, x_o;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    shiftcc_unit uut (
        .clk(clk), .rst(rst), .val_i(val_i), .cnt_i(cnt_i), .kind_i(kind_i),
        .prev_c_i(prev_c_i), .res_o(res_o), .n_o(n_o), .z_o(z_o), .v_o(v_o),
        .c_o(c_o), .x_o(x_o)
    );

    // Reference from the requirements: returns {carry, result}.
    function automatic logic [32:0] model(input logic [1:0] k, input logic [7:0] cnt,
                                          input logic pc, input logic [31:0] v);
        int n;
        n = int'(cnt) % 64;
        if (n == 0 || k == 2'b11) return {pc, v};
        case (k)
            2'b00: begin
                if (n < 32)       return {v[32-n], v << n};
                else if (n == 32) return {v[0], 32'h0};
                else              return 33'h0;
            end
            2'b01: begin
                if (n < 32)       return {v[n-1], v >> n};
                else if (n == 32) return {v[31], 32'h0};
                else              return 33'h0;
            end
            default: begin
                if (n < 32) return {v[n-1], 32'($signed(v) >>> n)};
                else        return {v[31], {32{v[31]}}};
            end
        endcase
    endfunction

    task automatic compare(input string tag, input logic [31:0] er, input logic ec,
                           input logic en, input logic ez, input logic ex);
        compared++;
        if (res_o !== er || c_o !== ec || n_o !== en || z_o !== ez || v_o !== 1'b0 || x_o !== ex) begin
            mismatched++;
            $display("FAIL %s: got res=%h n=%b z=%b v=%b c=%b x=%b, expected res=%h n=%b z=%b v=0 c=%b x=%b",
                     tag, res_o, n_o, z_o, v_o, c_o, x_o, er, en, ez, ec, ex);
        end
    endtask

    // Called at a falling edge; returns at the falling edge after the capture edge.
    task automatic run(input string tag, input logic [1:0] k, input logic [7:0] cnt,
                       input logic pc, input logic [31:0] v,
                       input logic [31:0] er, input logic ec);
        kind_i = k; cnt_i = cnt; prev_c_i = pc; val_i = v;
        @(posedge clk);
        @(negedge clk);
        // R6: X follows C; R7: N and Z from the result; R8: V clear
        compare(tag, er, ec, er[31], er == 32'h0, ec);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        compared++;
        mismatched++;
        $display("FAIL watchdog: got no completion, expected completion before timeout");
        finish_run();
    end

    initial begin
        logic [32:0] m;
        // R10: reset clears result and flags even with active inputs
        @(negedge clk);
        kind_i = 2'b10; cnt_i = 8'd3; prev_c_i = 1'b1; val_i = 32'h8000_0008;
        @(posedge clk);
        @(negedge clk);
        compare("R10 reset", 32'h0, 1'b0, 1'b0, 1'b0, 1'b0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            run($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].kind, VECS[i].cnt,
                VECS[i].pc, VECS[i].val, VECS[i].res, VECS[i].c);
        end

        // R3 R4 R5 R6: sweep every count for each shift kind
        for (int k = 0; k < 3; k++) begin
            for (int n = 0; n < 64; n++) begin
                m = model(2'(k), 8'(n), n[0], 32'hC3A5_5A3C);
                run($sformatf("R%0d sweep count %0d", k + 3, n), 2'(k), 8'(n), n[0],
                    32'hC3A5_5A3C, m[31:0], m[32]);
            end
        end

        // R10: reset again mid-run
        rst = 1'b1;
        kind_i = 2'b00; cnt_i = 8'd1; val_i = 32'hFFFF_FFFF;
        @(posedge clk);
        @(negedge clk);
        compare("R10 second reset", 32'h0, 1'b0, 1'b0, 1'b0, 1'b0);
        rst = 1'b0;

        finish_run();
    end

endmodule